// File: doc/BRIEF.md
# STN Frame-Rate Dithering Unit

This block turns 4-bit shade levels into single ON/OFF values for a passive-matrix LCD, using frame-rate control. A programmable table holds one 12-bit pattern for each shade level. The pattern is split into three 4-bit nibbles. The frame number picks the nibble, and the position of the value inside a group of four consecutive values picks the bit. This makes a shade flicker at a density that varies over both time and space.

Pixels enter one per cycle while a data-enable is high. Frame-start and line-start markers frame the stream. In monochrome mode each pixel yields one value. In colour mode each pixel yields three values, red then green then blue, and each component takes its own position slot. The dithered values are packed most significant lane first onto a 4-bit or 8-bit panel bus. Each full word is presented for one cycle together with a shift enable. A partial word is flushed with zero padding when a line or frame marker arrives. For dual-scan panels, one instance drives each half.

Top module: `frc_dither_unit`

## Requirements
- R1: After reset, level 0 holds an all-zero pattern and level 15 holds an all-one pattern, so those levels always give OFF and ON values.
- R2: A cycle with `pat_wr_en` high stores `pat_wr_val` as the pattern of level `pat_wr_lvl`, and pixels from the next cycle on use it.
- R3: The first frame after reset uses pattern bits [11:8]. Each later `frame_start` moves to [7:4], then [3:0], then wraps back to [11:8].
- R4: Within a line, the value with serial index j (counted from 0, reset by `line_start` and `frame_start`) equals pattern bit 11 − 4·f − (j mod 4), where f is the frame index 0..2.
- R5: In colour mode every pixel yields three serial values in the order red, green, blue, each taking the next index. In monochrome mode a pixel yields one value from `pix_red`.
- R6: On the 4-bit bus, each word carries four values: the earliest on `lcd_data[3]`, the latest on `lcd_data[0]`. `lcd_data[7:4]` stays zero.
- R7: On the 8-bit bus, each word carries eight values: the earliest on `lcd_data[7]`, the latest on `lcd_data[0]`.
- R8: `lcd_shift_en` is high for exactly one cycle, the cycle after the input cycle that completes a word. `lcd_data` is zero whenever `lcd_shift_en` is low.
- R9: A `line_start` or `frame_start` that finds a partial word emits that word on the next cycle, with the unfilled lanes zero. Nothing is emitted when no values are pending.
- R10: `color_mode_in` (1 = colour) and `bus_wide_in` (1 = 8-bit) are taken only in a `frame_start` cycle. Changing them at other times has no effect on the output.
- R11: During and right after reset, `lcd_shift_en` is low and `lcd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_wr_en | input | 1 | Pattern table write strobe |
| pat_wr_lvl | input | 4 | Shade level whose pattern is written |
| pat_wr_val | input | 12 | Pattern value written |
| frame_start | input | 1 | Frame marker pulse; also starts a line |
| line_start | input | 1 | Line marker pulse |
| pix_valid | input | 1 | Pixel data enable |
| pix_red | input | 4 | Red shade level, or the mono shade level |
| pix_grn | input | 4 | Green shade level |
| pix_blu | input | 4 | Blue shade level |
| color_mode_in | input | 1 | 1 = colour, 0 = monochrome; sampled at frame start |
| bus_wide_in | input | 1 | 1 = 8-bit bus, 0 = 4-bit bus; sampled at frame start |
| lcd_data | output | 8 | Panel data word |
| lcd_shift_en | output | 1 | Word-valid shift enable |

## Verification
The checker assumes that a marker cycle (`line_start` or `frame_start`) never also carries a pixel, and that the configuration inputs matter only in frame-start cycles. Under these assumptions a shift enable can only follow a pixel or a flush, and a narrow word can never touch the upper lanes. The directed stimulus always keeps `pix_valid` low during marker cycles. It deliberately moves the mode and width pins mid-frame, only to show that they are ignored there.

// File: rtl/frc_dither_pkg.sv
package frc_dither_pkg;

   typedef enum logic {
      PIX_MONO  = 1'b0,
      PIX_COLOR = 1'b1
   } frc_pix_mode_e;

   typedef enum logic {
      LANES_NARROW = 1'b0,
      LANES_WIDE   = 1'b1
   } frc_lanes_e;

   // number of serial values one colour pixel contributes
   localparam int unsigned FRC_COMPONENTS = 3;

endpackage

// File: rtl/frc_pattern_table.sv
module frc_pattern_table #(
   parameter int unsigned LVL_W = 4,
   parameter int unsigned PAT_W = 12,
   parameter int unsigned NRD   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [LVL_W-1:0]          wr_lvl,
   input  logic [PAT_W-1:0]          wr_val,
   input  logic [NRD-1:0][LVL_W-1:0] rd_lvl,
   output logic [NRD-1:0][PAT_W-1:0] rd_pat
);
   localparam int unsigned LEVELS = 1 << LVL_W;

   logic [PAT_W-1:0] entry_q [LEVELS];

   for (genvar e = 0; e < LEVELS; e++) begin : g_entry
      // top level defaults to solid ON, every other level to solid OFF
      localparam logic [PAT_W-1:0] RST_VAL = (e == LEVELS - 1) ? '1 : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entry_q[e] <= RST_VAL;
         end else if (wr_en && (wr_lvl == LVL_W'(e))) begin
            entry_q[e] <= wr_val;
         end
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_pat[r] = entry_q[rd_lvl[r]];
   end

endmodule

// File: rtl/frc_bit_pick.sv
module frc_bit_pick #(
   parameter int unsigned GROUP  = 4,
   parameter int unsigned FRAMES = 3,
   localparam int unsigned PAT_W  = GROUP * FRAMES,
   localparam int unsigned FIDX_W = $clog2(FRAMES),
   localparam int unsigned POS_W  = $clog2(GROUP),
   localparam int unsigned SH_W   = $clog2(PAT_W)
) (
   input  logic [PAT_W-1:0]  pat,
   input  logic [FIDX_W-1:0] fidx,
   input  logic [POS_W-1:0]  pos,
   output logic              on
);
   logic [SH_W-1:0]  shamt;
   logic [PAT_W-1:0] aligned;

   // frame picks the nibble from the top, position picks the bit inside it
   always_comb begin
      shamt   = SH_W'(fidx) * SH_W'(GROUP) + SH_W'(pos);
      aligned = pat << shamt;
      on      = aligned[PAT_W-1];
   end

endmodule

// File: rtl/frc_frame_seq.sv
module frc_frame_seq #(
   parameter int unsigned FRAMES = 3,
   parameter int unsigned GROUP  = 4,
   parameter int unsigned CHUNK  = 3,
   localparam int unsigned FIDX_W = $clog2(FRAMES),
   localparam int unsigned POS_W  = $clog2(GROUP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic              pix_valid,
   input  logic              color_in,
   input  logic              wide_in,
   output logic              color_q,
   output logic              wide_q,
   output logic [FIDX_W-1:0] fidx_q,
   output logic [POS_W-1:0]  pos_q
);
   logic             seen_frame_q;
   logic [POS_W-1:0] step;

   assign step = color_q ? POS_W'(CHUNK) : POS_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_frame_q <= 1'b0;
         fidx_q       <= '0;
         pos_q        <= '0;
         color_q      <= 1'b0;
         wide_q       <= 1'b0;
      end else if (frame_start) begin
         seen_frame_q <= 1'b1;
         if (!seen_frame_q || fidx_q == FIDX_W'(FRAMES - 1)) begin
            fidx_q <= '0;
         end else begin
            fidx_q <= fidx_q + 1'b1;
         end
         color_q <= color_in;
         wide_q  <= wide_in;
         pos_q   <= '0;
      end else if (line_start) begin
         pos_q <= '0;
      end else if (pix_valid) begin
         pos_q <= pos_q + step;  // wraps modulo GROUP
      end
   end

endmodule

// File: rtl/frc_lane_packer.sv
module frc_lane_packer #(
   parameter int unsigned BUS_NARROW = 4,
   parameter int unsigned BUS_WIDE   = 8,
   parameter int unsigned CHUNK      = 3,
   localparam int unsigned LEN_W = $clog2(CHUNK + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [LEN_W-1:0]    in_len,
   input  logic [CHUNK-1:0]    in_bits,
   input  logic                wide,
   input  logic                flush,
   output logic [BUS_WIDE-1:0] out_data,
   output logic                out_strobe
);
   localparam int unsigned ACC_W = BUS_WIDE + CHUNK - 1;
   localparam int unsigned CNT_W = $clog2(ACC_W + 1);

   logic [ACC_W-1:0]    acc_q, merged, rest, src;
   logic [CNT_W-1:0]    cnt_q, cnt_sum, lane_cnt;
   logic [BUS_WIDE-1:0] word;

   // accumulator is MSB-first: the oldest pending value sits in the top bit
   always_comb begin
      lane_cnt = wide ? CNT_W'(BUS_WIDE) : CNT_W'(BUS_NARROW);
      merged   = acc_q | ({in_bits, {(ACC_W - CHUNK){1'b0}}} >> cnt_q);
      cnt_sum  = cnt_q + CNT_W'(in_len);
      src      = flush ? acc_q : merged;
      if (wide) begin
         word = src[ACC_W-1 -: BUS_WIDE];
      end else begin
         word = {{(BUS_WIDE - BUS_NARROW){1'b0}}, src[ACC_W-1 -: BUS_NARROW]};
      end
      rest = merged << lane_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         cnt_q      <= '0;
         out_data   <= '0;
         out_strobe <= 1'b0;
      end else begin
         out_data   <= '0;
         out_strobe <= 1'b0;
         if (flush) begin
            if (cnt_q != '0) begin
               out_data   <= word;
               out_strobe <= 1'b1;
            end
            acc_q <= '0;
            cnt_q <= '0;
         end else if (in_valid) begin
            if (cnt_sum >= lane_cnt) begin
               out_data   <= word;
               out_strobe <= 1'b1;
               acc_q      <= rest;
               cnt_q      <= cnt_sum - lane_cnt;
            end else begin
               acc_q <= merged;
               cnt_q <= cnt_sum;
            end
         end
      end
   end

endmodule

// File: rtl/frc_dither_unit.sv
module frc_dither_unit #(
   parameter int unsigned LVL_W      = 4,
   parameter int unsigned GROUP      = 4,
   parameter int unsigned FRAMES     = 3,
   parameter int unsigned BUS_NARROW = 4,
   parameter int unsigned BUS_WIDE   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pat_wr_en,
   input  logic [LVL_W-1:0]        pat_wr_lvl,
   input  logic [GROUP*FRAMES-1:0] pat_wr_val,
   input  logic                    frame_start,
   input  logic                    line_start,
   input  logic                    pix_valid,
   input  logic [LVL_W-1:0]        pix_red,
   input  logic [LVL_W-1:0]        pix_grn,
   input  logic [LVL_W-1:0]        pix_blu,
   input  logic                    color_mode_in,
   input  logic                    bus_wide_in,
   output logic [BUS_WIDE-1:0]     lcd_data,
   output logic                    lcd_shift_en
);
   import frc_dither_pkg::*;

   localparam int unsigned CHUNK  = FRC_COMPONENTS;
   localparam int unsigned PAT_W  = GROUP * FRAMES;
   localparam int unsigned FIDX_W = $clog2(FRAMES);
   localparam int unsigned POS_W  = $clog2(GROUP);
   localparam int unsigned LEN_W  = $clog2(CHUNK + 1);

   if ((GROUP & (GROUP - 1)) != 0 || GROUP < 2) begin : g_chk_group
      $error("GROUP must be a power of two of at least 2");
   end
   if (FRAMES < 2) begin : g_chk_frames
      $error("FRAMES must be at least 2");
   end
   if (BUS_NARROW < CHUNK || BUS_WIDE <= BUS_NARROW) begin : g_chk_bus
      $error("need CHUNK <= BUS_NARROW < BUS_WIDE");
   end

   frc_pix_mode_e            pix_mode;
   frc_lanes_e               lanes;
   logic                     color_q, wide_q;
   logic [FIDX_W-1:0]        fidx;
   logic [POS_W-1:0]         pos;
   logic [CHUNK-1:0][LVL_W-1:0] comp_lvl;
   logic [CHUNK-1:0][PAT_W-1:0] comp_pat;
   logic [CHUNK-1:0]         comp_on;
   logic [CHUNK-1:0]         chunk_bits;
   logic [LEN_W-1:0]         chunk_len;
   logic                     flush;

   assign pix_mode = frc_pix_mode_e'(color_q);
   assign lanes    = frc_lanes_e'(wide_q);
   assign flush    = frame_start | line_start;

   frc_frame_seq #(.FRAMES(FRAMES), .GROUP(GROUP), .CHUNK(CHUNK)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_start  (line_start),
      .pix_valid   (pix_valid),
      .color_in    (color_mode_in),
      .wide_in     (bus_wide_in),
      .color_q     (color_q),
      .wide_q      (wide_q),
      .fidx_q      (fidx),
      .pos_q       (pos)
   );

   // component 0 is red (or mono), then green, then blue
   assign comp_lvl[0] = pix_red;
   assign comp_lvl[1] = pix_grn;
   assign comp_lvl[2] = pix_blu;

   frc_pattern_table #(.LVL_W(LVL_W), .PAT_W(PAT_W), .NRD(CHUNK)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pat_wr_en),
      .wr_lvl (pat_wr_lvl),
      .wr_val (pat_wr_val),
      .rd_lvl (comp_lvl),
      .rd_pat (comp_pat)
   );

   for (genvar g = 0; g < CHUNK; g++) begin : g_comp
      logic [POS_W-1:0] slot;
      assign slot = pos + POS_W'(g);
      frc_bit_pick #(.GROUP(GROUP), .FRAMES(FRAMES)) u_pick (
         .pat  (comp_pat[g]),
         .fidx (fidx),
         .pos  (slot),
         .on   (comp_on[g])
      );
   end

   always_comb begin
      if (pix_mode == PIX_COLOR) begin
         for (int i = 0; i < CHUNK; i++) begin
            chunk_bits[CHUNK-1-i] = comp_on[i];
         end
         chunk_len = LEN_W'(CHUNK);
      end else begin
         chunk_bits          = '0;
         chunk_bits[CHUNK-1] = comp_on[0];
         chunk_len           = LEN_W'(1);
      end
   end

   frc_lane_packer #(.BUS_NARROW(BUS_NARROW), .BUS_WIDE(BUS_WIDE), .CHUNK(CHUNK)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (pix_valid),
      .in_len     (chunk_len),
      .in_bits    (chunk_bits),
      .wide       (lanes == LANES_WIDE),
      .flush      (flush),
      .out_data   (lcd_data),
      .out_strobe (lcd_shift_en)
   );

endmodule

// File: rtl/frc_dither_checker.sv
module frc_dither_checker #(
   parameter int unsigned FRAMES     = 3,
   parameter int unsigned GROUP      = 4,
   parameter int unsigned BUS_NARROW = 4,
   parameter int unsigned BUS_WIDE   = 8,
   localparam int unsigned FIDX_W = $clog2(FRAMES),
   localparam int unsigned POS_W  = $clog2(GROUP)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_start,
   input logic                line_start,
   input logic                pix_valid,
   input logic [BUS_WIDE-1:0] lcd_data,
   input logic                lcd_shift_en,
   input logic                color_q,
   input logic                wide_q,
   input logic [FIDX_W-1:0]   fidx,
   input logic [POS_W-1:0]    pos
);

   a_r8_idle_data_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_shift_en |-> lcd_data == '0);

   a_r8_strobe_needs_cause : assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_valid || line_start || frame_start) |=> !lcd_shift_en);

   a_r6_narrow_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_shift_en && !$past(wide_q)) |-> lcd_data[BUS_WIDE-1:BUS_NARROW] == '0);

   a_r3_frame_index_range : assert property (@(posedge clk) disable iff (!rst_n)
      fidx <= FIDX_W'(FRAMES - 1));

   a_r3_frame_index_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(fidx));

   a_r10_config_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(color_q) && $stable(wide_q)));

   a_r4_position_restart : assert property (@(posedge clk) disable iff (!rst_n)
      (line_start || frame_start) |=> pos == '0);

   a_r11_reset_quiet : assert property (@(posedge clk)
      !rst_n |=> (!lcd_shift_en && lcd_data == '0));

endmodule

bind frc_dither_unit frc_dither_checker #(
   .FRAMES(FRAMES), .GROUP(GROUP), .BUS_NARROW(BUS_NARROW), .BUS_WIDE(BUS_WIDE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_start  (frame_start),
   .line_start   (line_start),
   .pix_valid    (pix_valid),
   .lcd_data     (lcd_data),
   .lcd_shift_en (lcd_shift_en),
   .color_q      (color_q),
   .wide_q       (wide_q),
   .fidx         (fidx),
   .pos          (pos)
);

// File: tb/frc_dither_unit_bench.sv
module frc_dither_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pat_wr_en = 1'b0;
   logic [3:0]  pat_wr_lvl = '0;
   logic [11:0] pat_wr_val = '0;
   logic        frame_start = 1'b0;
   logic        line_start = 1'b0;
   logic        pix_valid = 1'b0;
   logic [3:0]  pix_red = '0, pix_grn = '0, pix_blu = '0;
   logic        color_mode_in = 1'b0;
   logic        bus_wide_in = 1'b0;
   logic [7:0]  lcd_data;
   logic        lcd_shift_en;

   int total = 0;
   int bad = 0;

   // bench-side model state
   logic [11:0] mpat [16];
   int          mframe = -1;
   bit          mcolor = 0;
   bit          mwide = 0;
   logic [7:0]  got [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   frc_dither_unit u_frc_dither_unit (
      .clk (clk), .rst_n (rst_n),
      .pat_wr_en (pat_wr_en), .pat_wr_lvl (pat_wr_lvl), .pat_wr_val (pat_wr_val),
      .frame_start (frame_start), .line_start (line_start), .pix_valid (pix_valid),
      .pix_red (pix_red), .pix_grn (pix_grn), .pix_blu (pix_blu),
      .color_mode_in (color_mode_in), .bus_wide_in (bus_wide_in),
      .lcd_data (lcd_data), .lcd_shift_en (lcd_shift_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      if (lcd_shift_en) got.push_back(lcd_data);
   endtask

   function automatic int shade(input int seed, input int i, input int c);
      return (seed + 5 * i + 3 * c) % 16;
   endfunction

   task automatic write_pat(input int lvl, input logic [11:0] val);
      pat_wr_en  = 1'b1;
      pat_wr_lvl = 4'(lvl);
      pat_wr_val = val;
      tick();
      pat_wr_en  = 1'b0;
      mpat[lvl]  = val;
   endtask

   task automatic begin_frame(input bit color, input bit wide);
      color_mode_in = color;
      bus_wide_in   = wide;
      frame_start   = 1'b1;
      tick();
      frame_start   = 1'b0;
      mcolor = color;
      mwide  = wide;
      mframe = (mframe < 0) ? 0 : (mframe + 1) % 3;
   endtask

   // drive one line; fixed >= 0 forces every component to that level
   task automatic run_line(input int npix, input int seed, input int fixed, input string req);
      logic bits [$];
      logic [7:0] exp_w [$];
      int lanes, j, ncomp;
      got.delete();
      line_start = 1'b1;
      tick();
      line_start = 1'b0;
      j = 0;
      ncomp = mcolor ? 3 : 1;
      for (int i = 0; i < npix; i++) begin
         int lv [3];
         for (int c = 0; c < 3; c++) lv[c] = (fixed >= 0) ? fixed : shade(seed, i, c);
         pix_red = 4'(lv[0]);
         pix_grn = 4'(lv[1]);
         pix_blu = 4'(lv[2]);
         pix_valid = 1'b1;
         for (int c = 0; c < ncomp; c++) begin
            bits.push_back(mpat[lv[c]][11 - 4 * mframe - (j % 4)]);
            j++;
         end
         tick();
      end
      pix_valid = 1'b0;
      line_start = 1'b1;
      tick();
      line_start = 1'b0;
      tick();
      lanes = mwide ? 8 : 4;
      for (int b = 0; b < bits.size(); b += lanes) begin
         logic [7:0] w = '0;
         for (int k = 0; k < lanes; k++)
            if (b + k < bits.size()) w[lanes - 1 - k] = bits[b + k];
         exp_w.push_back(w);
      end
      check(got.size() == exp_w.size(), {req, " R8 word count"}, got.size(), exp_w.size());
      for (int k = 0; k < exp_w.size() && k < got.size(); k++)
         check(got[k] == exp_w[k], req, got[k], exp_w[k]);
   endtask

   task automatic t_reset_state();
      check(lcd_shift_en == 1'b0, "R11 shift enable in reset", lcd_shift_en, 0);
      check(lcd_data == 8'h00, "R11 data in reset", lcd_data, 0);
      rst_n = 1'b1;
      tick();
      tick();
      check(lcd_shift_en == 1'b0 && lcd_data == 8'h00, "R11 after release", lcd_data, 0);
   endtask

   task automatic t_default_levels();
      begin_frame(0, 0);
      run_line(8, 0, 15, "R1 level 15 solid ON");
      run_line(8, 0, 0, "R1 level 0 solid OFF");
   endtask

   task automatic t_program_and_frames();
      write_pat(10, 12'b1101_1011_0110);
      for (int l = 1; l < 15; l++)
         if (l != 10) write_pat(l, 12'((l * 12'h2A7 + 12'h135) & 12'hFFF));
      // R2 R3 R4 R6: level 10 over four frames, mono on the 4-bit bus
      for (int f = 0; f < 4; f++) begin
         begin_frame(0, 0);
         run_line(8, 0, 10, "R3 R4 R6 frame nibble sequence");
      end
      begin_frame(0, 0);
      run_line(7, 2, -1, "R2 R4 mixed levels mono");
   endtask

   task automatic t_color_narrow();
      begin_frame(1, 0);
      run_line(5, 3, -1, "R5 R9 colour narrow padded");
      run_line(4, 9, -1, "R5 colour narrow exact");
   endtask

   task automatic t_wide();
      begin_frame(0, 1);
      run_line(10, 1, -1, "R7 R9 mono wide padded");
      begin_frame(1, 1);
      run_line(7, 6, -1, "R7 R5 colour wide");
   endtask

   task automatic t_cfg_hold();
      begin_frame(0, 0);
      color_mode_in = 1'b1;
      bus_wide_in   = 1'b1;
      run_line(6, 4, -1, "R10 mid-frame config ignored");
      begin_frame(1, 1);
      run_line(4, 8, -1, "R10 config taken at frame start");
   endtask

   task automatic t_short_lines();
      begin_frame(0, 0);
      run_line(3, 5, -1, "R4 R9 short line one");
      run_line(3, 11, -1, "R4 R9 short line two");
      got.delete();
      line_start = 1'b1;
      tick();
      line_start = 1'b0;
      tick();
      check(got.size() == 0, "R9 empty flush emits nothing", got.size(), 0);
   endtask

   initial begin
      for (int l = 0; l < 16; l++) mpat[l] = (l == 15) ? 12'hFFF : 12'h000;
      repeat (3) @(posedge clk);
      #1;
      t_reset_state();
      t_default_levels();
      t_program_and_frames();
      t_color_narrow();
      t_wide();
      t_cfg_hold();
      t_short_lines();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule